// File: doc/BRIEF.md
# Sector DMA Transfer Engine

This engine moves exactly one disk sector of 12-bit words between a word-addressed memory port and a drive data port. A one-cycle `start` pulse stands for the expiry of the drive's positioning timer. On that pulse the engine checks the drive condition and latches the direction, the size (a full sector of 256 words or a half sector of 128 words) and the 3-bit memory field. It then streams the words, one per handshake. In the drive-to-memory direction, once the drive reports that the stored medium has run out, the engine stops taking words from the drive and stores zero words in memory instead. In the memory-to-drive direction, a half sector is followed by zero words so that the drive always receives a whole sector.

Memory addresses are 15 bits wide: the latched field sits above a 12-bit current-address register. The register counts up once for each word moved. When it runs past the top of the 4K field it goes back to address 0 of the same field, and the field bits never change. At the end of a transfer the register holds its start value plus the requested length, modulo 4096. `done` is then raised, `busy` drops, and the interrupt output is recomputed. The sector base offset for the drive is `{cyl_hi, sector}` shifted left by eight bits and is held stable for the whole transfer.

Top module: `sector_mover`

## Requirements
- R1: After reset `busy`, `done`, `not_ready`, `drv_err`, `wr_lock`, `irq`, `mem_valid`, `drv_wvalid` and `drv_rready` are 0 and `cur_addr` is 0.
- R2: A transfer moves 128 data words when `half` is 1 at start, and 256 data words when `half` is 0.
- R3: Data word k uses memory address `{field, (A0 + k) mod 4096}`, where A0 is `cur_addr` at start. The field bits stay fixed even when the low 12 bits wrap.
- R4: From the cycle after an accepted start, `drv_base` equals (`cyl_hi`·4096 + `sector`)·256, using the values sampled at start.
- R5: With `to_drive` = 1 (memory to drive) and `half` = 1, the 128 data words are followed by 128 zero words on the drive port, 256 in total.
- R6: With `to_drive` = 0 (drive to memory), a word moved while `drv_end` = 1 is written to memory as zero, and `drv_rready` stays low.
- R7: At completion `cur_addr` = (A0 + length) mod 4096, `done` = 1 and `busy` = 0.
- R8: A start with `attached` = 0 sets `done`, `not_ready` and `drv_err`, leaves `busy` at 0, and causes no port traffic. `cur_addr` is left unchanged.
- R9: A start with `to_drive` = 1 and `wprot` = 1 sets `done` and `wr_lock` and moves no words. A start with `to_drive` = 0 ignores `wprot`.
- R10: `irq` = `irq_en` AND (`done` OR `not_ready` OR `drv_err` OR `wr_lock`).
- R11: An accepted start clears `done` and all status bits. A start while `busy` = 1 is ignored, and the running transfer keeps its direction, length and drive state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ma_load | input | 1 | Load `cur_addr` from `ma_value` while idle |
| ma_value | input | 12 | Value for the current-address register |
| start | input | 1 | Positioning timer expired: begin service |
| to_drive | input | 1 | 1 = memory to drive, 0 = drive to memory |
| half | input | 1 | 1 = 128-word sector, 0 = 256-word sector |
| field | input | 3 | Memory field placed above the 12-bit address |
| cyl_hi | input | 1 | High cylinder bit of the disk address |
| sector | input | 12 | Low 12 bits of the disk address |
| attached | input | 1 | Drive is present and ready |
| wprot | input | 1 | Drive is write protected |
| irq_en | input | 1 | Interrupt enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Service finished |
| not_ready | output | 1 | Drive was absent at start |
| drv_err | output | 1 | Drive status error |
| wr_lock | output | 1 | Write refused on a protected drive |
| irq | output | 1 | Interrupt request |
| cur_addr | output | 12 | Current-address register |
| drv_base | output | 21 | Drive word offset of the sector |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts; for a read, `mem_rdata` is valid |
| mem_write | output | 1 | 1 = write memory, 0 = read memory |
| mem_addr | output | 15 | Physical memory address |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data |
| drv_wvalid | output | 1 | Word offered to the drive |
| drv_wready | input | 1 | Drive accepts a word |
| drv_wdata | output | 12 | Word to the drive |
| drv_rvalid | input | 1 | Drive offers a word |
| drv_rready | output | 1 | Engine takes the drive word |
| drv_rdata | input | 12 | Word from the drive |
| drv_end | input | 1 | Medium exhausted: no more drive words |

## Verification
A sweep runs every field value in both directions and both sector sizes, each from a different starting address, so that runs with and without a field wrap both occur. Memory data is a function of the address, so a wrong wrap or a carry into the field bits shows up as wrong drive data. Drive data is a function of the word index, so it exposes dropped or repeated words. Runs that end the medium early tell zero fill apart from real data. Random stalls on both sides separate the handshake from word counting. Runs with the drive absent or protected, and a start pulsed in the middle of a transfer, check that the rejection and ignore paths leave address, traffic and length untouched.

// File: rtl/sxf_pkg.sv
package sxf_pkg;

    localparam int ADDR_W  = 12;
    localparam int WORD_W  = 12;
    localparam int FIELD_W = 3;

    typedef enum logic [1:0] {
        SX_IDLE = 2'd0,
        SX_DATA = 2'd1,
        SX_PAD  = 2'd2
    } sx_state_e;

    typedef struct packed {
        logic               to_drive;
        logic               half;
        logic [FIELD_W-1:0] field;
    } sx_cfg_t;

    typedef struct packed {
        logic done;
        logic not_ready;
        logic drv_err;
        logic wr_lock;
    } sx_stat_t;

    function automatic int unsigned sx_words(input logic half_sel,
                                             input int unsigned full_n,
                                             input int unsigned half_n);
        return half_sel ? half_n : full_n;
    endfunction

endpackage

// File: rtl/sxf_addr_gen.sv
module sxf_addr_gen #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr
);

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (step)
            addr <= addr + 1'b1;
    end

    // R3: a step moves the low address by one and wraps inside the field
    p_wrap_step_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> addr == AW'($past(addr) + 1'b1));

endmodule

// File: rtl/sxf_counter.sv
module sxf_counter #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    output logic          last
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (step)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CW'(1));

    // R2: no word is moved once the count is exhausted
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
        step |-> cnt != '0);

endmodule

// File: rtl/sxf_seq.sv
module sxf_seq
    import sxf_pkg::*;
#(
    parameter int CW       = 9,
    parameter int FULL_LEN = 256,
    parameter int HALF_LEN = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          attached,
    input  logic          wprot,
    input  logic          to_drive_in,
    input  logic          half_in,
    input  logic          to_drive_q,
    input  logic          half_q,
    input  logic          fire,
    input  logic          last,
    output sx_state_e     state,
    output sx_stat_t      stat,
    output logic          go,
    output logic          cnt_load,
    output logic [CW-1:0] cnt_val
);

    localparam int PAD_LEN = FULL_LEN - HALF_LEN;

    logic accept, ok, to_pad, finish;

    always_comb begin
        accept   = start && (state == SX_IDLE);
        ok       = attached && !(to_drive_in && wprot);
        go       = accept && ok;
        to_pad   = fire && last && (state == SX_DATA) && to_drive_q && half_q;
        finish   = fire && last &&
                   ((state == SX_PAD) ||
                    ((state == SX_DATA) && !(to_drive_q && half_q)));
        cnt_load = go || to_pad;
        cnt_val  = go ? CW'(sx_words(half_in, FULL_LEN, HALF_LEN))
                      : CW'(PAD_LEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SX_IDLE;
            stat  <= '0;
        end else if (accept) begin
            stat.done      <= !ok;
            stat.not_ready <= !attached;
            stat.drv_err   <= !attached;
            stat.wr_lock   <= attached && to_drive_in && wprot;
            state          <= ok ? SX_DATA : SX_IDLE;
        end else if (to_pad) begin
            state <= SX_PAD;
        end else if (finish) begin
            state     <= SX_IDLE;
            stat.done <= 1'b1;
        end
    end

    // R7: leaving a transfer always raises done
    p_busy_drop_done_r7: assert property (@(posedge clk) disable iff (rst)
        (state == SX_IDLE && $past(state) != SX_IDLE) |-> stat.done);

    // R8: an error condition never coexists with a running transfer
    p_err_no_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (stat.not_ready || stat.wr_lock) |-> state == SX_IDLE);

    // R5: zero padding only follows a half sector toward the drive
    p_pad_after_half_r5: assert property (@(posedge clk) disable iff (rst)
        (state == SX_PAD) |-> (to_drive_q && half_q));

endmodule

// File: rtl/sector_mover.sv
module sector_mover
    import sxf_pkg::*;
#(
    parameter int FULL_LEN = 256,
    parameter int HALF_LEN = 128
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                ma_load,
    input  logic [ADDR_W-1:0]                   ma_value,
    input  logic                                start,
    input  logic                                to_drive,
    input  logic                                half,
    input  logic [FIELD_W-1:0]                  field,
    input  logic                                cyl_hi,
    input  logic [ADDR_W-1:0]                   sector,
    input  logic                                attached,
    input  logic                                wprot,
    input  logic                                irq_en,
    output logic                                busy,
    output logic                                done,
    output logic                                not_ready,
    output logic                                drv_err,
    output logic                                wr_lock,
    output logic                                irq,
    output logic [ADDR_W-1:0]                   cur_addr,
    output logic [ADDR_W+$clog2(FULL_LEN):0]    drv_base,
    output logic                                mem_valid,
    input  logic                                mem_ready,
    output logic                                mem_write,
    output logic [FIELD_W+ADDR_W-1:0]           mem_addr,
    output logic [WORD_W-1:0]                   mem_wdata,
    input  logic [WORD_W-1:0]                   mem_rdata,
    output logic                                drv_wvalid,
    input  logic                                drv_wready,
    output logic [WORD_W-1:0]                   drv_wdata,
    input  logic                                drv_rvalid,
    output logic                                drv_rready,
    input  logic [WORD_W-1:0]                   drv_rdata,
    input  logic                                drv_end
);

    localparam int CW    = $clog2(FULL_LEN) + 1;
    localparam int OFF_W = $clog2(FULL_LEN);

    sx_state_e     state;
    sx_stat_t      stat;
    sx_cfg_t       cfg_q;
    logic [ADDR_W:0] sect_q;
    logic          go, cnt_load, last, fire, step;
    logic [CW-1:0] cnt_val;
    logic          in_data, in_pad, rd_dir, wr_dir;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            sect_q <= '0;
        end else if (go) begin
            cfg_q  <= '{to_drive: to_drive, half: half, field: field};
            sect_q <= {cyl_hi, sector};
        end
    end

    always_comb begin
        in_data    = (state == SX_DATA);
        in_pad     = (state == SX_PAD);
        rd_dir     = in_data && !cfg_q.to_drive;
        wr_dir     = in_data && cfg_q.to_drive;
        mem_valid  = wr_dir || (rd_dir && (drv_rvalid || drv_end));
        mem_write  = rd_dir;
        mem_addr   = {cfg_q.field, cur_addr};
        mem_wdata  = drv_end ? '0 : drv_rdata;
        drv_rready = rd_dir && mem_ready && !drv_end;
        drv_wvalid = (wr_dir && mem_ready) || in_pad;
        drv_wdata  = in_pad ? '0 : mem_rdata;
        fire       = (rd_dir && mem_ready && (drv_rvalid || drv_end)) ||
                     (wr_dir && mem_ready && drv_wready) ||
                     (in_pad && drv_wready);
        step       = fire && in_data;
        busy       = (state != SX_IDLE);
        done       = stat.done;
        not_ready  = stat.not_ready;
        drv_err    = stat.drv_err;
        wr_lock    = stat.wr_lock;
        irq        = irq_en && (stat.done || stat.not_ready ||
                                stat.drv_err || stat.wr_lock);
        drv_base   = {sect_q, {OFF_W{1'b0}}};
    end

    sxf_seq #(
        .CW       (CW),
        .FULL_LEN (FULL_LEN),
        .HALF_LEN (HALF_LEN)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .attached    (attached),
        .wprot       (wprot),
        .to_drive_in (to_drive),
        .half_in     (half),
        .to_drive_q  (cfg_q.to_drive),
        .half_q      (cfg_q.half),
        .fire        (fire),
        .last        (last),
        .state       (state),
        .stat        (stat),
        .go          (go),
        .cnt_load    (cnt_load),
        .cnt_val     (cnt_val)
    );

    sxf_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .step     (fire),
        .last     (last)
    );

    sxf_addr_gen #(.AW(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (ma_load && !busy),
        .load_val (ma_value),
        .step     (step),
        .addr     (cur_addr)
    );

    // R8: no port traffic while idle
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_valid && !drv_wvalid && !drv_rready));

    // R3: field bits of the physical address never move during a transfer
    p_field_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |->
            mem_addr[FIELD_W+ADDR_W-1:ADDR_W] == $past(mem_addr[FIELD_W+ADDR_W-1:ADDR_W]));

    // R4: drive base offset stays constant while busy
    p_base_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(drv_base));

endmodule

// File: tb/sim_sector_mover.sv
module sim_sector_mover;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ma_load = 1'b0;
    logic [11:0] ma_value = '0;
    logic        start = 1'b0, to_drive = 1'b0, half = 1'b0;
    logic [2:0]  field = '0;
    logic        cyl_hi = 1'b0;
    logic [11:0] sector = '0;
    logic        attached = 1'b1, wprot = 1'b0, irq_en = 1'b0;
    logic        busy, done, not_ready, drv_err, wr_lock, irq;
    logic [11:0] cur_addr;
    logic [20:0] drv_base;
    logic        mem_valid, mem_ready, mem_write;
    logic [14:0] mem_addr;
    logic [11:0] mem_wdata, mem_rdata;
    logic        drv_wvalid, drv_wready, drv_rvalid, drv_rready, drv_end;
    logic [11:0] drv_wdata, drv_rdata;

    int checks = 0, errors = 0;
    int drv_idx = 0, end_at = 1000;
    bit pend_rd = 0;
    logic rv_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int mem_cnt = 0, w_cnt = 0, rd_seen = 0, xfer_err = 0;
    int cur_len = 256, fld = 0, ma_start = 0;

    always #4 clk = ~clk;

    function automatic int gmem(input int a);
        return ((a * 13) ^ (a >>> 3) ^ 'h5A5) & 'hFFF;
    endfunction

    function automatic int fdrv(input int k);
        return ((k * 29 + 7) ^ 'h3C3) & 'hFFF;
    endfunction

    assign mem_rdata  = 12'(gmem(int'(mem_addr)));
    assign drv_rdata  = 12'(fdrv(drv_idx));
    assign drv_rvalid = rv_en && (drv_idx < end_at);
    assign drv_end    = (drv_idx >= end_at);

    sector_mover u0 (
        .clk(clk), .rst(rst), .ma_load(ma_load), .ma_value(ma_value),
        .start(start), .to_drive(to_drive), .half(half), .field(field),
        .cyl_hi(cyl_hi), .sector(sector), .attached(attached), .wprot(wprot),
        .irq_en(irq_en), .busy(busy), .done(done), .not_ready(not_ready),
        .drv_err(drv_err), .wr_lock(wr_lock), .irq(irq), .cur_addr(cur_addr),
        .drv_base(drv_base), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .drv_wvalid(drv_wvalid), .drv_wready(drv_wready),
        .drv_wdata(drv_wdata), .drv_rvalid(drv_rvalid), .drv_rready(drv_rready),
        .drv_rdata(drv_rdata), .drv_end(drv_end)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Port model: random stalls, word monitor (fires happen at the next posedge)
    initial begin
        forever begin
            @(negedge clk);
            if (pend_rd) drv_idx++;
            pend_rd = 0;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ready  = lfsr[0] | lfsr[3];
            drv_wready = lfsr[1] | lfsr[5];
            rv_en      = lfsr[2] | lfsr[7];
            #1;
            if (drv_rvalid && drv_rready) pend_rd = 1;
            if (mem_valid && mem_ready) begin
                if (mem_write) begin
                    int ea, ed;
                    ea = fld * 4096 + (ma_start + mem_cnt) % 4096;
                    ed = (mem_cnt < end_at) ? fdrv(mem_cnt) : 0;
                    if (int'(mem_addr) != ea || int'(mem_wdata) != ed) begin
                        xfer_err++;
                        $display("mismatch mem word %0d addr=%0h/%0h data=%0h/%0h",
                                 mem_cnt, mem_addr, ea, mem_wdata, ed);
                    end
                    mem_cnt++;
                end else begin
                    rd_seen++;
                end
            end
            if (drv_wvalid && drv_wready) begin
                int ed;
                ed = (w_cnt < cur_len) ? gmem(fld * 4096 + (ma_start + w_cnt) % 4096) : 0;
                if (int'(drv_wdata) != ed) begin
                    xfer_err++;
                    $display("mismatch drive word %0d data=%0h/%0h", w_cnt, drv_wdata, ed);
                end
                w_cnt++;
            end
        end
    end

    task automatic clear_track();
        mem_cnt = 0; w_cnt = 0; rd_seen = 0; xfer_err = 0; drv_idx = 0;
    endtask

    task automatic load_ma(input int m0);
        @(negedge clk); ma_load = 1'b1; ma_value = 12'(m0);
        @(negedge clk); ma_load = 1'b0;
    endtask

    task automatic run(input bit op, input bit h, input int f, input int m0,
                       input int ea, input bit ie, input bit wp, input bit poke);
        int cyc;
        int sec;
        load_ma(m0);
        sec = (m0 * 3 + f) & 'hFFF;
        to_drive = op; half = h; field = 3'(f); cyl_hi = f[0];
        sector = 12'(sec); attached = 1'b1; wprot = wp; irq_en = ie;
        cur_len = h ? 128 : 256; fld = f; ma_start = m0; end_at = ea;
        clear_track();
        start = 1'b1;
        @(negedge clk); start = 1'b0; #2;
        chk("R11 busy after start", int'(busy), 1);
        chk("R11 done cleared by start", int'(done), 0);
        chk("R4 drive base", int'(drv_base), ((f & 1) * 4096 + sec) * 256);
        if (poke) begin
            repeat (15) @(negedge clk);
            to_drive = !op; half = !h; attached = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0; to_drive = op; half = h; attached = 1'b1;
        end
        cyc = 0;
        while (busy && cyc < 5000) begin
            @(negedge clk); #2; cyc++;
        end
        chk("R7 busy dropped", int'(busy), 0);
        chk("R7 done set", int'(done), 1);
        chk("R7 final address", int'(cur_addr), (m0 + cur_len) % 4096);
        chk("R3 R6 word content", xfer_err, 0);
        if (!op) begin
            chk("R2 memory word count", mem_cnt, cur_len);
            chk("R2 no drive writes", w_cnt, 0);
        end else begin
            chk(h ? "R5 padded drive count" : "R2 drive word count", w_cnt, 256);
            chk("R2 memory reads only", mem_cnt, 0);
        end
        chk("R10 irq", int'(irq), int'(ie));
        if (poke) chk("R11 status after ignored start", int'(not_ready), 0);
    endtask

    task automatic run_err(input bit op, input bit att, input bit wp, input bit ie);
        load_ma('h555);
        to_drive = op; attached = att; wprot = wp; irq_en = ie; half = 1'b0;
        clear_track();
        start = 1'b1;
        @(negedge clk); start = 1'b0; #2;
        chk("R8 R9 busy stays low", int'(busy), 0);
        chk("R8 R9 done", int'(done), 1);
        chk("R8 not_ready", int'(not_ready), int'(!att));
        chk("R8 drv_err", int'(drv_err), int'(!att));
        chk("R9 wr_lock", int'(wr_lock), int'(att && op && wp));
        repeat (4) @(negedge clk);
        #2;
        chk("R8 R9 no traffic", mem_cnt + w_cnt + rd_seen, 0);
        chk("R8 R9 address kept", int'(cur_addr), 'h555);
        chk("R10 irq on error", int'(irq), int'(ie));
        attached = 1'b1; wprot = 1'b0;
    endtask

    initial begin
        #1_600_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 status", int'({not_ready, drv_err, wr_lock}), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 address", int'(cur_addr), 0);
        chk("R1 ports quiet", int'({mem_valid, drv_wvalid, drv_rready}), 0);

        // directed corners
        run(1'b0, 1'b1, 5, 'hFC0, 1000, 1'b1, 1'b0, 1'b0); // half read, field wrap
        run(1'b0, 1'b0, 3, 'hF00, 100, 1'b0, 1'b1, 1'b0);  // R6 medium end, R9 wprot ignored
        run(1'b1, 1'b1, 2, 'hFF0, 1000, 1'b1, 1'b0, 1'b0); // R5 padded half write with wrap
        run(1'b1, 1'b0, 7, 'h123, 1000, 1'b1, 1'b0, 1'b0); // full write
        run(1'b0, 1'b0, 1, 'h010, 1000, 1'b1, 1'b0, 1'b1); // R11 start ignored while busy
        run_err(1'b0, 1'b0, 1'b0, 1'b1);                   // R8 absent drive
        run_err(1'b1, 1'b1, 1'b1, 1'b1);                   // R9 protected write
        run_err(1'b1, 1'b0, 1'b1, 1'b0);                   // R8 absence wins

        // sweep: every field, both directions, both sizes
        for (int f = 0; f < 8; f++)
            for (int op = 0; op < 2; op++)
                for (int h = 0; h < 2; h++)
                    run(op[0], h[0], f, (f * 517 + op * 1000 + h * 2000 + 3900) & 'hFFF,
                        (f == 2) ? 50 : 1000, f[0], (op == 0), 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule